// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Glitch-Free Switchover

This block watches the primary system clock from the always-running internal oscillator. The internal clock is divided down to a slower sampling interval. On every sample tick the monitor checks that the primary domain has answered the previous request. A primary clock that has stopped cannot answer, so the tick declares a failure. The controller then forces the system clock multiplexer onto the internal oscillator and raises a sticky failure flag, which can be routed out as an interrupt. The switched state stays in place until a power-managed-mode entry strobe or a wake strobe ends it. The block never switches back to the failed source by itself.

The oscillator class input chooses how monitoring starts. External-clock and RC sources are monitored right after reset or wake. Crystal and resonator sources first run the system from the internal oscillator. They hand over to the primary only when both the start-up timer and the PLL lock timer report done. Failure detection stays masked during that wait, so a crystal that never starts raises no flag. During the wait, a power-managed entry that requests the internal clock turns the primary oscillator off.

The controller state machine has these states:
- STARTUP: waiting for start-up, running on internal, detection masked.
- RUN_PRI: on primary, monitored.
- RUN_INT: on internal by request, unmonitored.
- FAILSAFE: failure latched, on internal.
- PRI_OFF: start-up abandoned, primary oscillator disabled.

Its transitions are:
- STARTUP to RUN_PRI when the mode is not crystal or both timers are done.
- STARTUP to PRI_OFF on a power-managed entry that requests internal.
- RUN_PRI to FAILSAFE on a detected failure. This takes priority.
- RUN_PRI to RUN_INT on a power-managed entry that requests internal.
- RUN_INT to RUN_PRI on a power-managed entry that requests primary.
- FAILSAFE to RUN_PRI or RUN_INT on any power-managed entry, as requested.
- PRI_OFF to STARTUP on a power-managed entry that requests primary.
- Any state to STARTUP on wake.

Top module: `fail_safe_clkmon`

## Requirements
- R1: While `por_n_i` is low, `fs_active_o`, `fail_flag_o` and `fail_irq_o` are 0 and `pri_osc_en_o` is 1.
- R2: After reset with `osc_xtal_i`=0, `sys_clk_o` follows the primary clock. With `osc_xtal_i`=1 it follows the internal clock until both `ost_done_i` and `pll_lock_i` are 1, and then it follows the primary clock.
- R3: A primary clock that keeps running while selected never sets `fail_flag_o`.
- R4: When the selected primary clock stops, `fail_flag_o` and `fs_active_o` become 1 and `sys_clk_o` follows the internal clock. This happens within two sample intervals plus synchroniser latency.
- R5: While `fs_active_o` is 1, the block stays on the internal clock even if the primary clock resumes. It leaves only on `pm_enter_i` or `wake_i`.
- R6: A `pm_enter_i` pulse clears `fs_active_o` and selects the source named by `sel_int_req_i` (0 = primary, 1 = internal). The internal source is not monitored, so stopping the primary while on internal sets no flag.
- R7: `fail_flag_o` is sticky. Only a `flag_clr_i` pulse clears it, and that clear leaves `fs_active_o` unchanged.
- R8: `fail_irq_o` equals `fail_flag_o` AND `irq_en_i`. With `irq_en_i`=0, a failure still moves `sys_clk_o` to the internal clock.
- R9: In crystal mode before both timers are done, a primary clock that never starts raises no flag.
- R10: During crystal start-up, a `pm_enter_i` with `sel_int_req_i`=1 drives `pri_osc_en_o` to 0. A later `pm_enter_i` with `sel_int_req_i`=0 sets it back to 1 and restarts the start-up wait.
- R11: The two clock enables of the multiplexer are never both active. `sys_clk_o` always equals exactly one source, or is held low during a handover.
- R12: A `wake_i` pulse restarts start-up sequencing and clears `fs_active_o`, but keeps `fail_flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri_i | input | 1 | Primary system clock being monitored |
| clk_int_i | input | 1 | Always-running internal oscillator clock |
| por_n_i | input | 1 | Active-low asynchronous power-on reset |
| wake_i | input | 1 | Wake-from-sleep strobe (internal clock domain) |
| osc_xtal_i | input | 1 | 1 = crystal/resonator source, 0 = external or RC source |
| ost_done_i | input | 1 | Oscillator start-up timer has expired |
| pll_lock_i | input | 1 | PLL lock timer has expired |
| sel_int_req_i | input | 1 | Requested source on power-managed entry: 1 internal, 0 primary |
| pm_enter_i | input | 1 | Power-managed-mode entry strobe |
| flag_clr_i | input | 1 | Write-zero strobe for the failure flag |
| irq_en_i | input | 1 | Failure interrupt enable |
| sys_clk_o | output | 1 | Glitch-free selected system clock |
| fs_active_o | output | 1 | Fail-safe switchover is in effect |
| fail_flag_o | output | 1 | Sticky oscillator failure flag |
| fail_irq_o | output | 1 | Failure interrupt request |
| pri_osc_en_o | output | 1 | Primary oscillator enable |

## Verification
The assertions check the following on every internal clock cycle:
- the two multiplexer enables are never both on;
- a detected failure always sets the flag on the next cycle;
- the flag holds without a clear;
- the FAILSAFE state holds without an entry or wake strobe;
- start-up never moves straight into FAILSAFE;
- a disarmed monitor stays silent.

Only the bench scenarios can show the rest:
- that `sys_clk_o` really follows the expected source;
- that a stopped primary is caught within the sample window while a running one is never flagged;
- that the primary-disable and start-up sequences work from the ports.

// File: rtl/fscm_pkg.sv
`timescale 1ns/1ps
package fscm_pkg;

    typedef enum logic [2:0] {
        ST_STARTUP  = 3'd0,
        ST_RUN_PRI  = 3'd1,
        ST_RUN_INT  = 3'd2,
        ST_FAILSAFE = 3'd3,
        ST_PRI_OFF  = 3'd4
    } fscm_state_e;

    localparam int FSCM_MIN_SYNC = 2;

endpackage

// File: rtl/fscm_sync.sv
`timescale 1ns/1ps
module fscm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fscm_activity_mon.sv
`timescale 1ns/1ps
module fscm_activity_mon #(
    parameter int SAMPLE_DIV  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_pri_i,
    input  logic clk_int_i,
    input  logic rst_n_i,
    input  logic arm_i,
    output logic fail_o
);
    localparam int CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [CW-1:0] TICK_AT = CW'(SAMPLE_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          req_q;
    logic          first_q;
    logic          fail_q;
    logic          echo_pri;
    logic          ack_seen;

    // Primary domain echoes the request; a dead primary never echoes.
    fscm_sync #(.STAGES(SYNC_STAGES)) u_req_to_pri (
        .clk_i   (clk_pri_i),
        .rst_n_i (rst_n_i),
        .d_i     (req_q),
        .q_o     (echo_pri)
    );

    fscm_sync #(.STAGES(SYNC_STAGES)) u_ack_to_int (
        .clk_i   (clk_int_i),
        .rst_n_i (rst_n_i),
        .d_i     (echo_pri),
        .q_o     (ack_seen)
    );

    always_ff @(posedge clk_int_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q   <= '0;
            req_q   <= 1'b0;
            first_q <= 1'b1;
            fail_q  <= 1'b0;
        end else begin
            fail_q <= 1'b0;
            if (!arm_i) begin
                cnt_q   <= '0;
                first_q <= 1'b1;
            end else if (cnt_q == TICK_AT) begin
                cnt_q <= '0;
                if (first_q) begin
                    req_q   <= ~ack_seen;
                    first_q <= 1'b0;
                end else if (ack_seen == req_q) begin
                    req_q <= ~req_q;
                end else begin
                    fail_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign fail_o = fail_q;

    // R6
    disarm_quiet_chk: assert property (@(posedge clk_int_i) disable iff (!rst_n_i)
        !arm_i |=> !fail_q);

    // R4
    fail_single_chk: assert property (@(posedge clk_int_i) disable iff (!rst_n_i)
        fail_q |=> !fail_q);
endmodule

// File: rtl/fscm_glitchfree_mux.sv
`timescale 1ns/1ps
module fscm_glitchfree_mux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_pri_i,
    input  logic clk_int_i,
    input  logic rst_n_i,
    input  logic sel_int_i,
    input  logic force_int_i,
    output logic clk_o
);
    logic pri_rst_n;
    logic pri_req_s;
    logic int_req_s;
    logic en_pri_q;
    logic en_int_q;
    logic d_pri;
    logic d_int;

    // A dead primary cannot clock its own enable low: clear it asynchronously.
    assign pri_rst_n = rst_n_i & ~force_int_i;

    assign d_pri = ~sel_int_i & ~en_int_q & ~int_req_s;
    assign d_int =  sel_int_i & ~en_pri_q & ~pri_req_s;

    fscm_sync #(.STAGES(SYNC_STAGES)) u_pri_sync (
        .clk_i   (clk_pri_i),
        .rst_n_i (pri_rst_n),
        .d_i     (d_pri),
        .q_o     (pri_req_s)
    );

    fscm_sync #(.STAGES(SYNC_STAGES)) u_int_sync (
        .clk_i   (clk_int_i),
        .rst_n_i (rst_n_i),
        .d_i     (d_int),
        .q_o     (int_req_s)
    );

    // Enables change only while their clock is low.
    always_ff @(negedge clk_pri_i or negedge pri_rst_n) begin
        if (!pri_rst_n) en_pri_q <= 1'b0;
        else            en_pri_q <= pri_req_s;
    end

    always_ff @(negedge clk_int_i or negedge rst_n_i) begin
        if (!rst_n_i) en_int_q <= 1'b0;
        else          en_int_q <= int_req_s;
    end

    assign clk_o = (clk_pri_i & en_pri_q) | (clk_int_i & en_int_q);

    // R11
    both_en_excl_chk: assert property (@(posedge clk_int_i) disable iff (!rst_n_i)
        !(en_pri_q && en_int_q));
endmodule

// File: rtl/fscm_ctrl.sv
`timescale 1ns/1ps
module fscm_ctrl
    import fscm_pkg::*;
(
    input  logic clk_int_i,
    input  logic rst_n_i,
    input  logic wake_i,
    input  logic osc_xtal_i,
    input  logic ost_done_i,
    input  logic pll_lock_i,
    input  logic sel_int_req_i,
    input  logic pm_enter_i,
    input  logic flag_clr_i,
    input  logic irq_en_i,
    input  logic fail_i,
    output logic arm_o,
    output logic sel_int_o,
    output logic force_int_o,
    output logic fs_active_o,
    output logic fail_flag_o,
    output logic fail_irq_o,
    output logic pri_osc_en_o
);
    fscm_state_e state_q, state_d;
    logic        flag_q;
    logic        pri_ready;

    assign pri_ready = ~osc_xtal_i | (ost_done_i & pll_lock_i);

    always_ff @(posedge clk_int_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ST_STARTUP;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wake_i) begin
            state_d = ST_STARTUP;
        end else begin
            unique case (state_q)
                ST_STARTUP: begin
                    if (pri_ready)                        state_d = ST_RUN_PRI;
                    else if (pm_enter_i && sel_int_req_i) state_d = ST_PRI_OFF;
                end
                ST_RUN_PRI: begin
                    if (fail_i)                           state_d = ST_FAILSAFE;
                    else if (pm_enter_i && sel_int_req_i) state_d = ST_RUN_INT;
                end
                ST_RUN_INT: begin
                    if (pm_enter_i && !sel_int_req_i)     state_d = ST_RUN_PRI;
                end
                ST_FAILSAFE: begin
                    if (pm_enter_i)
                        state_d = sel_int_req_i ? ST_RUN_INT : ST_RUN_PRI;
                end
                ST_PRI_OFF: begin
                    if (pm_enter_i && !sel_int_req_i)     state_d = ST_STARTUP;
                end
                default:                                  state_d = ST_STARTUP;
            endcase
        end
    end

    always_ff @(posedge clk_int_i or negedge rst_n_i) begin
        if (!rst_n_i)        flag_q <= 1'b0;
        else if (fail_i)     flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    always_comb begin
        arm_o        = (state_q == ST_RUN_PRI);
        sel_int_o    = (state_q != ST_RUN_PRI);
        force_int_o  = (state_q == ST_FAILSAFE) || (state_q == ST_PRI_OFF);
        fs_active_o  = (state_q == ST_FAILSAFE);
        pri_osc_en_o = (state_q != ST_PRI_OFF);
        fail_flag_o  = flag_q;
        fail_irq_o   = flag_q & irq_en_i;
    end

    // R4
    flag_set_chk: assert property (@(posedge clk_int_i) disable iff (!rst_n_i)
        fail_i |=> flag_q);

    // R7
    flag_hold_chk: assert property (@(posedge clk_int_i) disable iff (!rst_n_i)
        (flag_q && !flag_clr_i) |=> flag_q);

    // R5
    fs_hold_chk: assert property (@(posedge clk_int_i) disable iff (!rst_n_i)
        (state_q == ST_FAILSAFE && !pm_enter_i && !wake_i) |=> (state_q == ST_FAILSAFE));

    // R9
    startup_mask_chk: assert property (@(posedge clk_int_i) disable iff (!rst_n_i)
        (state_q == ST_STARTUP) |=> (state_q != ST_FAILSAFE));
endmodule

// File: rtl/fail_safe_clkmon.sv
`timescale 1ns/1ps
module fail_safe_clkmon #(
    parameter int SAMPLE_DIV  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_pri_i,
    input  logic clk_int_i,
    input  logic por_n_i,
    input  logic wake_i,
    input  logic osc_xtal_i,
    input  logic ost_done_i,
    input  logic pll_lock_i,
    input  logic sel_int_req_i,
    input  logic pm_enter_i,
    input  logic flag_clr_i,
    input  logic irq_en_i,
    output logic sys_clk_o,
    output logic fs_active_o,
    output logic fail_flag_o,
    output logic fail_irq_o,
    output logic pri_osc_en_o
);
    localparam int SYNC_N = (SYNC_STAGES < fscm_pkg::FSCM_MIN_SYNC) ?
                            fscm_pkg::FSCM_MIN_SYNC : SYNC_STAGES;

    logic arm;
    logic fail;
    logic sel_int;
    logic force_int;

    fscm_activity_mon #(.SAMPLE_DIV(SAMPLE_DIV), .SYNC_STAGES(SYNC_N)) u_mon (
        .clk_pri_i (clk_pri_i),
        .clk_int_i (clk_int_i),
        .rst_n_i   (por_n_i),
        .arm_i     (arm),
        .fail_o    (fail)
    );

    fscm_ctrl u_ctrl (
        .clk_int_i     (clk_int_i),
        .rst_n_i       (por_n_i),
        .wake_i        (wake_i),
        .osc_xtal_i    (osc_xtal_i),
        .ost_done_i    (ost_done_i),
        .pll_lock_i    (pll_lock_i),
        .sel_int_req_i (sel_int_req_i),
        .pm_enter_i    (pm_enter_i),
        .flag_clr_i    (flag_clr_i),
        .irq_en_i      (irq_en_i),
        .fail_i        (fail),
        .arm_o         (arm),
        .sel_int_o     (sel_int),
        .force_int_o   (force_int),
        .fs_active_o   (fs_active_o),
        .fail_flag_o   (fail_flag_o),
        .fail_irq_o    (fail_irq_o),
        .pri_osc_en_o  (pri_osc_en_o)
    );

    fscm_glitchfree_mux #(.SYNC_STAGES(SYNC_N)) u_mux (
        .clk_pri_i   (clk_pri_i),
        .clk_int_i   (clk_int_i),
        .rst_n_i     (por_n_i),
        .sel_int_i   (sel_int),
        .force_int_i (force_int),
        .clk_o       (sys_clk_o)
    );
endmodule

// File: tb/fail_safe_clkmon_tb.sv
`timescale 1ns/1ps
module fail_safe_clkmon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SDIV       = 16;
    localparam int DETECT_WAIT = 3 * SDIV + 12;
    localparam int QUIET_WAIT  = 12 * SDIV;
    // fields: {osc_xtal, ost_done, pll_lock, expect internal source}
    localparam logic [3:0] START_TBL [6] = '{
        4'b0000, 4'b1001, 4'b1101, 4'b1011, 4'b1110, 4'b0110
    };

    logic clk_int = 1'b0;
    logic clk_pri = 1'b0;
    logic pri_run = 1'b1;
    logic por_n = 1'b0, wake = 1'b0, osc_xtal = 1'b0, ost_done = 1'b0, pll_lock = 1'b0;
    logic sel_int_req = 1'b0, pm_enter = 1'b0, flag_clr = 1'b0, irq_en = 1'b1;
    logic sys_clk, fs_active, fail_flag, fail_irq, pri_osc_en;
    int   n_tests = 0;
    int   n_fail  = 0;

    always #(CLK_PERIOD/2) clk_int = ~clk_int;
    always #2 clk_pri = pri_run ? ~clk_pri : 1'b0;

    fail_safe_clkmon #(.SAMPLE_DIV(SDIV)) u_dut (
        .clk_pri_i(clk_pri), .clk_int_i(clk_int), .por_n_i(por_n), .wake_i(wake),
        .osc_xtal_i(osc_xtal), .ost_done_i(ost_done), .pll_lock_i(pll_lock),
        .sel_int_req_i(sel_int_req), .pm_enter_i(pm_enter), .flag_clr_i(flag_clr),
        .irq_en_i(irq_en), .sys_clk_o(sys_clk), .fs_active_o(fs_active),
        .fail_flag_o(fail_flag), .fail_irq_o(fail_irq), .pri_osc_en_o(pri_osc_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk_int);
    endtask

    // Compare sys_clk with the expected source at half-ns points (never an edge).
    task automatic check_src(input string tag, input logic want_int);
        int mism = 0;
        int highs = 0;
        #0.5;
        for (int n = 0; n < 16; n++) begin
            if (sys_clk !== (want_int ? clk_int : clk_pri)) mism++;
            if (sys_clk === 1'b1) highs++;
            #1;
        end
        chk(tag, (mism == 0 && highs > 0) ? 1 : 0, 1);
        step(1);
    endtask

    task automatic do_reset;
        por_n = 1'b0;
        step(3);
        por_n = 1'b1;
    endtask

    task automatic pm_pulse(input logic want_int);
        sel_int_req = want_int;
        pm_enter = 1'b1;
        step(1);
        pm_enter = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        step(2);
        chk("R1 fs_active in reset", int'(fs_active), 0);
        chk("R1 flag in reset", int'(fail_flag), 0);
        chk("R1 irq in reset", int'(fail_irq), 0);
        chk("R1 pri_osc_en in reset", int'(pri_osc_en), 1);

        // R2: start-up source table
        for (int i = 0; i < 6; i++) begin
            osc_xtal = START_TBL[i][3];
            ost_done = START_TBL[i][2];
            pll_lock = START_TBL[i][1];
            do_reset();
            step(12);
            check_src($sformatf("R2 startup source row %0d", i), START_TBL[i][0]);
            chk($sformatf("R2 no fs row %0d", i), int'(fs_active), 0);
        end

        // R2: crystal hands over after timers complete
        osc_xtal = 1'b1; ost_done = 1'b0; pll_lock = 1'b0;
        do_reset();
        step(12);
        check_src("R2 crystal waits on internal", 1'b1);
        ost_done = 1'b1; pll_lock = 1'b1;
        step(12);
        check_src("R2 crystal ready to primary", 1'b0);

        // R3: running primary never flagged
        osc_xtal = 1'b0;
        do_reset();
        step(QUIET_WAIT);
        chk("R3 no false failure", int'(fail_flag), 0);

        // R4 / R8: primary stops
        pri_run = 1'b0;
        step(DETECT_WAIT);
        chk("R4 flag set", int'(fail_flag), 1);
        chk("R4 fs active", int'(fs_active), 1);
        chk("R8 irq with enable", int'(fail_irq), 1);
        check_src("R4 switched to internal", 1'b1);

        // R5: no automatic return
        pri_run = 1'b1;
        step(QUIET_WAIT);
        chk("R5 fs held", int'(fs_active), 1);
        check_src("R5 stays internal", 1'b1);

        // R7: flag clear leaves fs_active
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        step(2);
        chk("R7 flag cleared", int'(fail_flag), 0);
        chk("R7 fs unaffected", int'(fs_active), 1);

        // R6: power-managed entry back to primary
        pm_pulse(1'b0);
        step(12);
        chk("R6 fs cleared", int'(fs_active), 0);
        check_src("R6 primary selected", 1'b0);

        // R6: internal selection is unmonitored
        pm_pulse(1'b1);
        step(12);
        check_src("R6 internal selected", 1'b1);
        pri_run = 1'b0;
        step(QUIET_WAIT);
        chk("R6 no flag on internal", int'(fail_flag), 0);
        pri_run = 1'b1;
        pm_pulse(1'b0);
        step(12);
        check_src("R6 back to primary", 1'b0);

        // R8: failure with interrupt disabled
        irq_en = 1'b0;
        pri_run = 1'b0;
        step(DETECT_WAIT);
        chk("R8 flag without irq", int'(fail_flag), 1);
        chk("R8 irq masked", int'(fail_irq), 0);
        check_src("R8 runs on internal", 1'b1);
        irq_en = 1'b1;
        step(1);
        chk("R8 irq follows enable", int'(fail_irq), 1);

        // R12: wake restarts, flag kept
        pri_run = 1'b1;
        step(4);
        wake = 1'b1; step(1); wake = 1'b0;
        step(12);
        chk("R12 fs cleared by wake", int'(fs_active), 0);
        chk("R12 flag kept", int'(fail_flag), 1);
        check_src("R12 primary after wake", 1'b0);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;

        // R9: crystal that never starts
        osc_xtal = 1'b1; ost_done = 1'b0; pll_lock = 1'b0;
        pri_run = 1'b0;
        do_reset();
        step(QUIET_WAIT);
        chk("R9 no flag during startup", int'(fail_flag), 0);
        chk("R9 no fs during startup", int'(fs_active), 0);
        check_src("R9 on internal", 1'b1);

        // R10: primary disable during start-up
        pm_pulse(1'b1);
        step(2);
        chk("R10 primary disabled", int'(pri_osc_en), 0);
        check_src("R10 internal while off", 1'b1);
        pm_pulse(1'b0);
        step(2);
        chk("R10 primary re-enabled", int'(pri_osc_en), 1);
        pri_run = 1'b1;
        ost_done = 1'b1; pll_lock = 1'b1;
        step(12);
        check_src("R10 primary after restart", 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule